// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is the slave end of a two-channel serial audio link. It takes a bit clock, a frame clock that marks the left and right halves of each sample period, and a single data line. It returns one signed left sample and one signed right sample per frame, both valid together, with a one-cycle strobe. All three inputs are oversampled in the system clock domain. The bit clock must therefore be slower than a quarter of the system clock.

Two runtime inputs set the link format. The first picks the frame alignment: I2S, left-justified or right-justified. The second picks the word length: 16, 20 or 24 bits. Words shorter than the output width are placed at the top of the output, with zeros below them. The block also counts bit clocks in every frame. If that count changes from one frame to the next, it sets a sticky error flag, which stays set until a clear input is pulsed.

Top module: `sai_rx`

## Requirements
- R1: Data is sampled on rising bit-clock edges, MSB first. `fmt_i` codes: 0 = I2S, 1 = left-justified, 2 = right-justified, 3 = treated as left-justified. `wlen_i` codes: 0 = 16 bits, 1 = 20 bits, 2 = 24 bits, 3 = treated as 24 bits.
- R2: In I2S format, a low frame clock marks the left word and a high frame clock marks the right word. The MSB arrives on the second rising bit-clock edge after the frame clock changes. Bit slots after the word are ignored. When the word fills the whole half-frame, its LSB falls on the first edge of the next half.
- R3: In left-justified format, a high frame clock marks the left word. The MSB is on the first rising edge after the frame clock changes, and trailing bit slots are ignored.
- R4: In right-justified format, a high frame clock marks the left word. The LSB is on the last rising edge before the frame clock changes, and leading bit slots are ignored.
- R5: A 16-bit or 20-bit word appears in bits 23 down to 8, or 23 down to 4, of its 24-bit output. All bits below it are zero.
- R6: `valid_o` is high for exactly one clock after each completed right word that followed a completed left word. `left_o` and `right_o` change only in that cycle and hold their values otherwise.
- R7: Frames of 32, 48 and 64 bit clocks are received correctly in every format.
- R8: A frame whose bit-clock count differs from the frame before it sets `err_o`. `err_o` stays high until `err_clr_i` is pulsed. If a new mismatch arrives in the same cycle as the clear, `err_o` stays set.
- R9: After reset, no count comparison is made until one complete frame has been measured. A partial frame at start-up never raises `err_o`.
- R10: During and straight after reset, `left_o`, `right_o`, `valid_o` and `err_o` are all zero.
- R11: After reset, the first `valid_o` needs both a complete left word and a complete right word received after the first frame-clock edge. A stream that starts mid-frame and is followed by four full frames gives exactly three strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Frame (left/right) clock |
| sd_i | input | 1 | Serial data |
| fmt_i | input | 2 | Frame alignment select |
| wlen_i | input | 2 | Word length select |
| err_clr_i | input | 1 | Clears the frame-length error flag |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| err_o | output | 1 | Sticky frame-length error |

## Verification
The bench sends 16-bit I2S words in 32-clock frames, where each LSB spills into the next half-frame. A receiver that closes the word on the raw frame-clock edge would lose that LSB. It also sends right-justified words shorter than the half-frame, where a receiver that kept leading bits would return shifted data. Left and right use different, asymmetric patterns, so swapped channel polarity shows up in the data checks. Finally, the bench starts a stream mid-frame straight after reset, then changes the frame length and pulses the clear. A design that compared against a partial first frame, emitted a pair before priming, or let the error flag drop without a clear would each fail a check.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  localparam int unsigned MAX_WORD = 24;

  function automatic logic [4:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    word_bits = 5'd16;
      2'd1:    word_bits = 5'd20;
      default: word_bits = 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic stb_o,
  output logic ws_o,
  output logic ws_prev_o,
  output logic sd_o,
  output logic first_o
);

  logic [STAGES-1:0][2:0] pipe_q;
  logic                   sck_d_q;
  logic                   seen_q;
  logic                   rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= {sck_i, ws_i, sd_i};
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[g] <= '0;
      else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  assign rise = pipe_q[STAGES-1][2] & ~sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q   <= 1'b0;
      stb_o     <= 1'b0;
      ws_o      <= 1'b0;
      ws_prev_o <= 1'b0;
      sd_o      <= 1'b0;
      first_o   <= 1'b1;
      seen_q    <= 1'b0;
    end else begin
      sck_d_q <= pipe_q[STAGES-1][2];
      stb_o   <= rise;
      if (rise) begin
        ws_prev_o <= ws_o;
        ws_o      <= pipe_q[STAGES-1][1];
        sd_o      <= pipe_q[STAGES-1][0];
        first_o   <= ~seen_q;
        seen_q    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sai_rx_deser.sv
module sai_rx_deser
  import sai_rx_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              ws_i,
  input  logic              ws_prev_i,
  input  logic              sd_i,
  input  logic              first_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  fmt_e              fmt;
  logic              is_i2s, is_rj;
  logic [4:0]        wb;
  logic              eff_ok, cur_eff, edge_hit, full, ch_left;
  logic [DATA_W-1:0] mask, aligned;

  logic              have_eff_q, eff_q, primed_q, left_ok_q;
  logic [DATA_W-1:0] shreg_q, left_hold_q;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    fmt      = fmt_e'(fmt_i);
    is_i2s   = (fmt == FMT_I2S);
    is_rj    = (fmt == FMT_RJ);
    wb       = word_bits(wlen_i);
    // I2S: word boundary trails the frame clock by one bit
    eff_ok   = !(is_i2s && first_i);
    cur_eff  = is_i2s ? ws_prev_i : ws_i;
    edge_hit = stb_i && eff_ok && have_eff_q && (cur_eff != eff_q);
    full     = int'(cnt_q) >= int'(wb);
    ch_left  = is_i2s ? ~eff_q : eff_q;
    mask     = {DATA_W{1'b1}} >> (DATA_W - int'(wb));
    aligned  = (shreg_q & mask) << (DATA_W - int'(wb));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_eff_q  <= 1'b0;
      eff_q       <= 1'b0;
      primed_q    <= 1'b0;
      left_ok_q   <= 1'b0;
      shreg_q     <= '0;
      left_hold_q <= '0;
      cnt_q       <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (stb_i && eff_ok) begin
        have_eff_q <= 1'b1;
        eff_q      <= cur_eff;
      end
      if (edge_hit) begin
        if (primed_q && full) begin
          if (ch_left) begin
            left_hold_q <= aligned;
            left_ok_q   <= 1'b1;
          end else if (left_ok_q) begin
            left_o    <= left_hold_q;
            right_o   <= aligned;
            valid_o   <= 1'b1;
            left_ok_q <= 1'b0;
          end
        end else begin
          left_ok_q <= 1'b0;
        end
        primed_q <= 1'b1;
        shreg_q  <= {shreg_q[DATA_W-2:0], sd_i};
        cnt_q    <= CNT_W'(1);
      end else if (stb_i) begin
        // right-justified keeps shifting so the last bits win
        if (is_rj || !full) shreg_q <= {shreg_q[DATA_W-2:0], sd_i};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sai_rx_frame_mon.sv
module sai_rx_frame_mon #(
  parameter int FLEN_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic ws_i,
  input  logic ws_prev_i,
  input  logic first_i,
  input  logic clr_i,
  output logic err_o
);

  logic [FLEN_W-1:0] cnt_q, ref_q;
  logic              armed_q, have_ref_q;
  logic              frame_rise, mismatch;

  assign frame_rise = stb_i && !first_i && ws_i && !ws_prev_i;
  assign mismatch   = frame_rise && armed_q && have_ref_q && (cnt_q != ref_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      ref_q      <= '0;
      armed_q    <= 1'b0;
      have_ref_q <= 1'b0;
    end else if (frame_rise) begin
      if (armed_q) begin
        ref_q      <= cnt_q;
        have_ref_q <= 1'b1;
      end
      armed_q <= 1'b1;
      cnt_q   <= FLEN_W'(1);
    end else if (stb_i && armed_q && cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (mismatch) err_o <= 1'b1;
    else if (clr_i)    err_o <= 1'b0;
  end

endmodule

// File: rtl/sai_rx.sv
module sai_rx #(
  parameter int DATA_W      = 24,
  parameter int SYNC_STAGES = 2,
  parameter int FLEN_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        wlen_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o,
  output logic              err_o
);

  logic stb, ws_s, ws_prev_s, sd_s, first_s;

  sai_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (sck_i),
    .ws_i      (ws_i),
    .sd_i      (sd_i),
    .stb_o     (stb),
    .ws_o      (ws_s),
    .ws_prev_o (ws_prev_s),
    .sd_o      (sd_s),
    .first_o   (first_s)
  );

  sai_rx_deser #(.DATA_W(DATA_W)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb),
    .ws_i      (ws_s),
    .ws_prev_i (ws_prev_s),
    .sd_i      (sd_s),
    .first_i   (first_s),
    .fmt_i     (fmt_i),
    .wlen_i    (wlen_i),
    .left_o    (left_o),
    .right_o   (right_o),
    .valid_o   (valid_o)
  );

  sai_rx_frame_mon #(.FLEN_W(FLEN_W)) u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb),
    .ws_i      (ws_s),
    .ws_prev_i (ws_prev_s),
    .first_i   (first_s),
    .clr_i     (err_clr_i),
    .err_o     (err_o)
  );

endmodule

// File: rtl/sai_rx_chk.sv
module sai_rx_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              err_clr_i,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic              valid_o,
  input logic              err_o
);

  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r6_left_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(left_o) |-> valid_o);

  a_r6_right_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(right_o) |-> valid_o);

  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);

  a_r8_err_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(err_clr_i));

endmodule

bind sai_rx sai_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .err_clr_i (err_clr_i),
  .left_o    (left_o),
  .right_o   (right_o),
  .valid_o   (valid_o),
  .err_o     (err_o)
);

// File: tb/sai_rx_tb.sv
`timescale 1ns/1ps
module sai_rx_tb;

  localparam int SCK_HALF = 32;
  localparam int NV = 9;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck_i = 1'b0;
  logic        ws_i = 1'b0;
  logic        sd_i = 1'b0;
  logic [1:0]  fmt_i = 2'd0;
  logic [1:0]  wlen_i = 2'd0;
  logic        err_clr_i = 1'b0;
  logic [23:0] left_o, right_o;
  logic        valid_o, err_o;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  logic [23:0] cap_l = '0, cap_r = '0;

  always #2 clk_i = ~clk_i;

  sai_rx u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
    .fmt_i(fmt_i), .wlen_i(wlen_i), .err_clr_i(err_clr_i),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o), .err_o(err_o)
  );

  always @(negedge clk_i) begin
    if (valid_o) begin
      cap_l  <= left_o;
      cap_r  <= right_o;
      vcount <= vcount + 1;
    end
  end

  // fmt, wlen code, bits per frame, left, right
  localparam logic [1:0]  VF [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd2, 2'd2, 2'd1, 2'd1};
  localparam logic [1:0]  VW [NV] = '{2'd0, 2'd2, 2'd1, 2'd1, 2'd2, 2'd0, 2'd1, 2'd0, 2'd3};
  localparam int          VB [NV] = '{32, 64, 48, 48, 64, 32, 48, 32, 64};
  localparam logic [23:0] VL [NV] = '{24'hA5C3F1, 24'h812345, 24'hF0F0F7, 24'h123456,
                                      24'h800001, 24'hBEEF55, 24'hC0FFEE, 24'h8000FF, 24'hDEADBE};
  localparam logic [23:0] VR [NV] = '{24'h3C5A7E, 24'h7EDCBA, 24'h0F0F08, 24'hFEDCBA,
                                      24'h7FFFFE, 24'h1234AA, 24'h55AA33, 24'h7FFF01, 24'h010203};
  localparam string       VT [NV] = '{"R2", "R2", "R2", "R3", "R4", "R4", "R4", "R3", "R1"};

  function automatic int wbits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : 24;
  endfunction

  function automatic logic [23:0] expv(input logic [23:0] v, input int w);
    return v & (24'hFFFFFF << (24 - w));
  endfunction

  function automatic logic gen_bit(input logic [1:0] f, input int w, input int h, input int k,
                                   input logic [23:0] cur, input logic [23:0] prv);
    if (f == 2'd2) return (k >= h - w) ? cur[h - 1 - k + 24 - w] : 1'b0;
    if (f == 2'd0) begin
      if (k >= 1 && k <= w) return cur[24 - k];
      if (k == 0 && w == h) return prv[24 - w];
      return 1'b0;
    end
    return (k < w) ? cur[23 - k] : 1'b0;
  endfunction

  task automatic drive_bit(input logic ws, input logic b);
    sck_i = 1'b0; ws_i = ws; sd_i = b;
    #(SCK_HALF);
    sck_i = 1'b1;
    #(SCK_HALF);
  endtask

  task automatic send_frame(input logic [1:0] f, input int w, input int bpf,
                            input logic [23:0] l, input logic [23:0] r);
    int h = bpf / 2;
    logic first_ws = (f == 2'd0) ? 1'b0 : 1'b1;
    for (int j = 0; j < bpf; j++) begin
      if (j < h) drive_bit(first_ws, gen_bit(f, w, h, j, l, r));
      else       drive_bit(~first_ws, gen_bit(f, w, h, j - h, r, l));
    end
  endtask

  task automatic idle_gap();
    sck_i = 1'b0;
    #(SCK_HALF * 4);
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk_i); err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int w;
    // R10: reset state
    #10;
    check(valid_o == 1'b0, "R10 valid", 32'(valid_o), 0);
    check(err_o == 1'b0, "R10 err", 32'(err_o), 0);
    check(left_o == '0, "R10 left", 32'(left_o), 0);
    check(right_o == '0, "R10 right", 32'(right_o), 0);
    #7 rst_ni = 1'b1;
    #20;

    // vector walk: R1..R5 and R7 frame sizes
    for (int i = 0; i < NV; i++) begin
      fmt_i = VF[i]; wlen_i = VW[i];
      w = wbits(VW[i]);
      for (int n = 0; n < 4; n++) send_frame(VF[i], w, VB[i], VL[i], VR[i]);
      idle_gap();
      check(cap_l == expv(VL[i], w), {VT[i], " R5 R7 left"}, 32'(cap_l), 32'(expv(VL[i], w)));
      check(cap_r == expv(VR[i], w), {VT[i], " R5 R7 right"}, 32'(cap_r), 32'(expv(VR[i], w)));
    end

    // R8: no error at steady length, set on change, sticky, cleared by pulse
    pulse_clr();
    check(err_o == 1'b0, "R8 clear", 32'(err_o), 0);
    for (int n = 0; n < 3; n++) send_frame(2'd1, 24, 64, 24'h111111, 24'h222222);
    idle_gap();
    check(err_o == 1'b0, "R8 steady", 32'(err_o), 0);
    for (int n = 0; n < 2; n++) send_frame(2'd1, 24, 48, 24'h111111, 24'h222222);
    idle_gap();
    check(err_o == 1'b1, "R8 change", 32'(err_o), 1);
    for (int n = 0; n < 3; n++) send_frame(2'd1, 24, 48, 24'h111111, 24'h222222);
    idle_gap();
    check(err_o == 1'b1, "R8 sticky", 32'(err_o), 1);
    pulse_clr();
    check(err_o == 1'b0, "R8 cleared", 32'(err_o), 0);

    // R9, R11: restart mid-frame after reset
    @(negedge clk_i); rst_ni = 1'b0;
    #10;
    check(left_o == '0 && right_o == '0, "R10 second reset data", 32'(left_o), 0);
    check(err_o == 1'b0 && valid_o == 1'b0, "R10 second reset flags", {30'd0, err_o, valid_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    vcount = 0;
    fmt_i = 2'd1; wlen_i = 2'd2;
    for (int k = 0; k < 5; k++) drive_bit(1'b0, k[0]);
    for (int n = 0; n < 4; n++) send_frame(2'd1, 24, 48, 24'h5A0F3C, 24'hA1B2C3);
    idle_gap();
    check(err_o == 1'b0, "R9 partial first frame", 32'(err_o), 0);
    check(vcount == 3, "R11 strobe count", 32'(vcount), 3);
    check(cap_l == 24'h5A0F3C, "R11 left", 32'(cap_l), 32'h5A0F3C);
    check(cap_r == 24'hA1B2C3, "R11 right", 32'(cap_r), 32'hA1B2C3);

    finish_run();
  end

endmodule